// File: doc/BRIEF.md
# INT8 Requantization Scale Unit

This unit turns the signed 32-bit accumulator results of an integer convolution or matrix multiply back into signed 8-bit values. The per-tensor combined scale, equal to the input scale times the weight scale divided by the output scale, is computed elsewhere. It is written to the unit once as a single-precision bit pattern, together with the output zero point. From that pattern the unit takes a fixed-point multiplier and a right-shift count directly from the exponent and mantissa bits. No general float-to-fixed conversion takes place.

Each accumulator value that enters on the valid/ready input stream is multiplied at full width. The product is shifted right with rounding half away from zero, the output zero point is added, and the sum is clamped to the INT8 range. The datapath is a three-stage pipeline that stalls as a whole when the consumer withholds ready. A configuration write affects only samples accepted after it, so a new tensor's scale can be loaded while results of the previous tensor are still in flight.

Top module: `requant_unit`

## Requirements
- R1: The shift count equals 142 minus E, where E is the unsigned 8-bit exponent field, bits [30:23] of the scale pattern. The sign bit 31 has no effect.
- R2: The multiplier equals the unsigned 15-bit field at bits [23:9] of the scale pattern plus one, giving a range of 1 to 32768. The signed accumulator is multiplied by it without loss of width.
- R3: For a positive shift count s, the product is divided by 2^s and rounded to the nearest integer, with exact halves rounded away from zero. For example, 32768 with s = 16 yields 1 and -32768 yields -1.
- R4: A shift count of zero or below leaves the product unshifted.
- R5: Any shift count at or above the product width yields a shifted value of 0, for example with the reset configuration of scale pattern 0 (shift 142).
- R6: The signed 8-bit output zero point is added after rounding. The sum saturates to the range -128 to 127.
- R7: While out_ready stays high, a sample accepted on one clock edge appears on out_valid/out_data after the third edge counting that one. Back-to-back samples are accepted and delivered one per cycle in order.
- R8: While out_valid is high and out_ready is low, out_data holds steady. Once three samples are held the unit deasserts in_ready. No sample is lost, duplicated or reordered.
- R9: A configuration write applies to samples accepted on later edges. A sample accepted on the same edge as the write, and any sample already in flight, uses the previous settings.
- R10: After reset out_valid is low, in_ready is high, and the configuration equals a scale pattern of 0 with a zero point of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Load cfg_scale and cfg_zero_point on this edge |
| cfg_scale | input | 32 | Combined scale as a single-precision bit pattern |
| cfg_zero_point | input | OUT_W | Signed output zero point |
| in_valid | input | 1 | Accumulator sample present |
| in_ready | output | 1 | Unit accepts a sample on this edge |
| in_acc | input | ACC_W | Signed accumulator value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_data | output | OUT_W | Signed saturated result |

## Verification
The bench builds the unit with its default widths of a 32-bit accumulator and an 8-bit output. With these widths the product spans 49 bits, so the accumulator extremes ±2^31 with the largest multiplier exercise the full product. Shift patterns below zero, in range, and past the product width are then reachable with real exponent values. Exact half-way products exercise both rounding directions, and zero points of either sign drive both saturation limits.

// File: rtl/requant_pkg.sv
package requant_pkg;
    // Exponent field of a single-precision pattern
    localparam int unsigned FP_EXP_LSB = 23;
    localparam int unsigned FP_EXP_W   = 8;
    // Multiplier field: 15 bits starting at bit 9 (overlaps the exponent LSB)
    localparam int unsigned FIELD_LSB  = 9;
    localparam int unsigned FIELD_W    = 15;
    // Shift offset: bias plus fixed-point alignment terms
    localparam int          SHIFT_BASE = 127 + 31 - 32 + 16;
    // Width of the signed raw shift count
    localparam int unsigned SHR_W      = 10;
endpackage

// File: rtl/requant_cfg.sv
module requant_cfg
    import requant_pkg::*;
#(
    parameter int unsigned OUT_W  = 8,
    parameter int unsigned MULT_W = FIELD_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_valid,
    input  logic [31:0]              cfg_scale,
    input  logic [OUT_W-1:0]         cfg_zero_point,
    output logic [MULT_W-1:0]        mult_o,
    output logic signed [SHR_W-1:0]  shift_o,
    output logic signed [OUT_W-1:0]  zp_o
);
    typedef struct packed {
        logic [MULT_W-1:0]       mult;
        logic signed [SHR_W-1:0] shift;
        logic signed [OUT_W-1:0] zp;
    } cfg_t;

    localparam logic signed [SHR_W-1:0] BASE_S = SHR_W'(SHIFT_BASE);

    cfg_t cfg_d, cfg_q;
    logic [FP_EXP_W-1:0]       exp_field;
    logic [FIELD_W-1:0]        mant_field;
    logic signed [SHR_W-1:0]   exp_ext;

    always_comb begin
        exp_field  = cfg_scale[FP_EXP_LSB +: FP_EXP_W];
        mant_field = cfg_scale[FIELD_LSB +: FIELD_W];
        exp_ext    = $signed({{(SHR_W-FP_EXP_W){1'b0}}, exp_field});
        cfg_d      = cfg_q;
        if (cfg_valid) begin
            cfg_d.mult  = MULT_W'(mant_field) + MULT_W'(1);
            cfg_d.shift = BASE_S - exp_ext;
            cfg_d.zp    = $signed(cfg_zero_point);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mult  <= MULT_W'(1);
            cfg_q.shift <= BASE_S;
            cfg_q.zp    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mult_o  = cfg_q.mult;
    assign shift_o = cfg_q.shift;
    assign zp_o    = cfg_q.zp;
endmodule

// File: rtl/requant_mul.sv
module requant_mul
    import requant_pkg::*;
#(
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned OUT_W  = 8,
    parameter int unsigned MULT_W = FIELD_W + 1,
    parameter int unsigned PROD_W = ACC_W + MULT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     valid_i,
    input  logic [ACC_W-1:0]         acc_i,
    input  logic [MULT_W-1:0]        mult_i,
    input  logic signed [SHR_W-1:0]  shift_i,
    input  logic signed [OUT_W-1:0]  zp_i,
    output logic                     valid_o,
    output logic signed [PROD_W-1:0] prod_o,
    output logic signed [SHR_W-1:0]  shift_o,
    output logic signed [OUT_W-1:0]  zp_o
);
    typedef struct packed {
        logic                     valid;
        logic signed [PROD_W-1:0] prod;
        logic signed [SHR_W-1:0]  shift;
        logic signed [OUT_W-1:0]  zp;
    } s1_t;

    s1_t s1_d, s1_q;
    logic signed [PROD_W-1:0] acc_ext;
    logic signed [PROD_W-1:0] mult_ext;

    always_comb begin
        acc_ext  = $signed({{(PROD_W-ACC_W){acc_i[ACC_W-1]}}, acc_i});
        mult_ext = $signed({{(PROD_W-MULT_W){1'b0}}, mult_i});
        s1_d     = s1_q;
        if (en) begin
            s1_d.valid = valid_i;
            s1_d.prod  = acc_ext * mult_ext;
            s1_d.shift = shift_i;
            s1_d.zp    = zp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    assign valid_o = s1_q.valid;
    assign prod_o  = s1_q.prod;
    assign shift_o = s1_q.shift;
    assign zp_o    = s1_q.zp;
endmodule

// File: rtl/requant_round.sv
module requant_round
    import requant_pkg::*;
#(
    parameter int unsigned OUT_W  = 8,
    parameter int unsigned PROD_W = 49,
    parameter int unsigned MAG_W  = PROD_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     valid_i,
    input  logic signed [PROD_W-1:0] prod_i,
    input  logic signed [SHR_W-1:0]  shift_i,
    input  logic signed [OUT_W-1:0]  zp_i,
    output logic                     valid_o,
    output logic signed [MAG_W-1:0]  val_o,
    output logic signed [OUT_W-1:0]  zp_o
);
    // Shifts at or past the product width all round to zero
    localparam int unsigned SH_MAX = PROD_W;
    localparam int unsigned SH_W   = $clog2(SH_MAX + 1);
    localparam logic signed [SHR_W-1:0] SH_MAX_S = SHR_W'(SH_MAX);

    typedef struct packed {
        logic                    valid;
        logic signed [MAG_W-1:0] val;
        logic signed [OUT_W-1:0] zp;
    } s2_t;

    s2_t s2_d, s2_q;
    logic [SH_W-1:0]         amt;
    logic                    neg;
    logic signed [MAG_W-1:0] prod_ext;
    logic [MAG_W-1:0]        mag;
    logic [MAG_W-1:0]        half;
    logic [MAG_W-1:0]        quot;
    logic signed [MAG_W-1:0] quot_s;

    always_comb begin
        if (shift_i <= $signed(SHR_W'(0))) begin
            amt = '0;
        end else if (shift_i >= SH_MAX_S) begin
            amt = SH_W'(SH_MAX);
        end else begin
            amt = shift_i[SH_W-1:0];
        end
        neg      = prod_i[PROD_W-1];
        prod_ext = $signed({prod_i[PROD_W-1], prod_i});
        mag      = neg ? MAG_W'(-prod_ext) : MAG_W'(prod_ext);
        half     = (amt == '0) ? '0 : (MAG_W'(1) << (amt - SH_W'(1)));
        quot     = (mag + half) >> amt;
        quot_s   = $signed(quot);
        s2_d     = s2_q;
        if (en) begin
            s2_d.valid = valid_i;
            s2_d.val   = neg ? -quot_s : quot_s;
            s2_d.zp    = zp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_q <= '0;
        end else begin
            s2_q <= s2_d;
        end
    end

    assign valid_o = s2_q.valid;
    assign val_o   = s2_q.val;
    assign zp_o    = s2_q.zp;
endmodule

// File: rtl/requant_sat.sv
module requant_sat #(
    parameter int unsigned OUT_W = 8,
    parameter int unsigned MAG_W = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    valid_i,
    input  logic signed [MAG_W-1:0] val_i,
    input  logic signed [OUT_W-1:0] zp_i,
    output logic                    valid_o,
    output logic [OUT_W-1:0]        data_o
);
    localparam int unsigned SUM_W = MAG_W + 1;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] data;
    } s3_t;

    s3_t s3_d, s3_q;
    logic signed [SUM_W-1:0] val_ext;
    logic signed [SUM_W-1:0] zp_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        val_ext = $signed({val_i[MAG_W-1], val_i});
        zp_ext  = $signed({{(SUM_W-OUT_W){zp_i[OUT_W-1]}}, zp_i});
        sum     = val_ext + zp_ext;
        s3_d    = s3_q;
        if (en) begin
            s3_d.valid = valid_i;
            if (sum > SAT_HI) begin
                s3_d.data = SAT_HI[OUT_W-1:0];
            end else if (sum < SAT_LO) begin
                s3_d.data = SAT_LO[OUT_W-1:0];
            end else begin
                s3_d.data = sum[OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_q <= '0;
        end else begin
            s3_q <= s3_d;
        end
    end

    assign valid_o = s3_q.valid;
    assign data_o  = s3_q.data;
endmodule

// File: rtl/requant_unit.sv
module requant_unit
    import requant_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [31:0]      cfg_scale,
    input  logic [OUT_W-1:0] cfg_zero_point,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ACC_W-1:0] in_acc,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    localparam int unsigned MULT_W = FIELD_W + 1;
    localparam int unsigned PROD_W = ACC_W + MULT_W + 1;
    localparam int unsigned MAG_W  = PROD_W + 1;

    logic [MULT_W-1:0]       cfg_mult;
    logic signed [SHR_W-1:0] cfg_shift;
    logic signed [OUT_W-1:0] cfg_zp;

    logic                     s1_valid;
    logic signed [PROD_W-1:0] s1_prod;
    logic signed [SHR_W-1:0]  s1_shift;
    logic signed [OUT_W-1:0]  s1_zp;

    logic                     s2_valid;
    logic signed [MAG_W-1:0]  s2_val;
    logic signed [OUT_W-1:0]  s2_zp;

    logic s3_valid;
    logic advance;

    // Whole pipeline moves together; it only stops when the last stage is held
    assign advance  = !s3_valid || out_ready;
    assign in_ready = advance;

    requant_cfg #(.OUT_W(OUT_W), .MULT_W(MULT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_scale(cfg_scale), .cfg_zero_point(cfg_zero_point),
        .mult_o(cfg_mult), .shift_o(cfg_shift), .zp_o(cfg_zp)
    );

    requant_mul #(.ACC_W(ACC_W), .OUT_W(OUT_W), .MULT_W(MULT_W), .PROD_W(PROD_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .valid_i(in_valid), .acc_i(in_acc),
        .mult_i(cfg_mult), .shift_i(cfg_shift), .zp_i(cfg_zp),
        .valid_o(s1_valid), .prod_o(s1_prod), .shift_o(s1_shift), .zp_o(s1_zp)
    );

    requant_round #(.OUT_W(OUT_W), .PROD_W(PROD_W), .MAG_W(MAG_W)) u_round (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .valid_i(s1_valid), .prod_i(s1_prod), .shift_i(s1_shift), .zp_i(s1_zp),
        .valid_o(s2_valid), .val_o(s2_val), .zp_o(s2_zp)
    );

    requant_sat #(.OUT_W(OUT_W), .MAG_W(MAG_W)) u_sat (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .valid_i(s2_valid), .val_i(s2_val), .zp_i(s2_zp),
        .valid_o(s3_valid), .data_o(out_data)
    );

    assign out_valid = s3_valid;
endmodule

// File: rtl/requant_unit_chk.sv
module requant_unit_chk #(
    parameter int unsigned OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);
    logic [1:0] age_q;
    logic [2:0] held_q;
    logic       accept;
    logic       deliver;

    assign accept  = in_valid && in_ready;
    assign deliver = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q  <= '0;
            held_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            held_q <= held_q + 3'(accept) - 3'(deliver);
        end
    end

    // R10: nothing valid in the first cycle after reset release
    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R8: a held result stays put
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: never more than three samples in flight
    assert_occupancy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= 3'd3);

    // R8: no result without a sample behind it
    assert_no_phantom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (held_q != 3'd0));

    // R7: fixed latency when the consumer keeps pulling
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(accept, 3) && $past(out_ready, 2) && $past(out_ready, 1))
        |-> out_valid);
endmodule

bind requant_unit requant_unit_chk #(.OUT_W(OUT_W)) chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/requant_unit_test.sv
module requant_unit_test;
    localparam int ACC_W = 32;
    localparam int OUT_W = 8;
    localparam int NV    = 26;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [31:0]      cfg_scale = '0;
    logic [OUT_W-1:0] cfg_zero_point = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [ACC_W-1:0] in_acc = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [OUT_W-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    requant_unit #(.ACC_W(ACC_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_scale(cfg_scale), .cfg_zero_point(cfg_zero_point),
        .in_valid(in_valid), .in_ready(in_ready), .in_acc(in_acc),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // {req, scale, zero point, accumulator, expected}
    localparam logic [83:0] VEC [NV] = '{
        {4'd2, 32'h3F800000,  8'sd0,   32'sd100,         8'sd50},   // R2 mult 16385, shift 15
        {4'd2, 32'h3F800000,  8'sd0,  -32'sd100,        -8'sd50},   // R2
        {4'd3, 32'h3F800000,  8'sd0,   32'sd1,           8'sd1},    // R3 just above half
        {4'd2, 32'h3FC00000,  8'sd0,   32'sd100,         8'sd75},   // R2 mult 24577
        {4'd2, 32'h3FC00000,  8'sd0,  -32'sd100,        -8'sd75},   // R2
        {4'd2, 32'h3FFFFE00,  8'sd0,   32'sd77,          8'sd77},   // R2 mult 32768
        {4'd2, 32'h3FFFFE00,  8'sd0,  -32'sd77,         -8'sd77},   // R2
        {4'd3, 32'h3F000000,  8'sd0,   32'sd32768,       8'sd1},    // R3 exact half up
        {4'd3, 32'h3F000000,  8'sd0,  -32'sd32768,      -8'sd1},    // R3 exact half down
        {4'd3, 32'h3F000000,  8'sd0,   32'sd32767,       8'sd0},    // R3 below half
        {4'd3, 32'h3F000000,  8'sd0,   32'sd98304,       8'sd2},    // R3 1.5 -> 2
        {4'd3, 32'h3F000000,  8'sd0,  -32'sd98304,      -8'sd2},    // R3 -1.5 -> -2
        {4'd1, 32'h43000000,  8'sd0,   32'sd384,         8'sd2},    // R1 shift 8
        {4'd3, 32'h43000000,  8'sd0,  -32'sd128,        -8'sd1},    // R3 -0.5 -> -1
        {4'd1, 32'h43000000,  8'sd0,   32'sd127,         8'sd0},    // R1
        {4'd1, 32'hBF000000,  8'sd0,   32'sd32768,       8'sd1},    // R1 sign bit ignored
        {4'd4, 32'h47000000,  8'sd0,   32'sd5,           8'sd5},    // R4 shift 0
        {4'd4, 32'h4B000000,  8'sd0,  -32'sd7,          -8'sd7},    // R4 shift -8
        {4'd5, 32'h00000000,  8'sd0,   32'sh7FFFFFFF,    8'sd0},    // R5 shift 142
        {4'd5, 32'h00000000, -8'sd3,   32'sh80000000,   -8'sd3},    // R5
        {4'd6, 32'h3F000000,  8'sd0,   32'sh7FFFFFFF,    8'sd127},  // R6 upper clamp
        {4'd6, 32'h3F000000,  8'sd0,   32'sh80000000,   -8'sd128},  // R6 lower clamp
        {4'd6, 32'h47000000,  8'sd10,  32'sd120,         8'sd127},  // R6
        {4'd6, 32'h47000000, -8'sd10, -32'sd120,        -8'sd128},  // R6
        {4'd6, 32'h47000000,  8'sd20,  32'sd100,         8'sd120},  // R6
        {4'd6, 32'h47000000,  8'sd3,  -32'sd5,          -8'sd2}     // R6
    };

    task automatic check(input string req, input int got, input int expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic set_cfg(input logic [31:0] scale, input logic [7:0] zp);
        @(negedge clk);
        cfg_valid      = 1'b1;
        cfg_scale      = scale;
        cfg_zero_point = zp;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // One sample, out_ready high; result read after the third edge
    task automatic run_one(input logic [31:0] acc, output int got, output logic vld);
        @(negedge clk);
        in_valid = 1'b1;
        in_acc   = acc;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        vld = out_valid;
        got = int'($signed(out_data));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int  got;
        logic vld;
        int  nacc;
        int  seen [4];

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out_valid after reset", int'(out_valid), 0);
        check("R10 in_ready after reset", int'(in_ready), 1);
        cfg_zero_point = 8'd77; // not loaded: cfg_valid stays low
        run_one(32'h7FFFFFFF, got, vld);
        check("R10 reset config valid", int'(vld), 1);
        check("R10 reset config result", got, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i][79:48], VEC[i][47:40]);
            run_one(VEC[i][39:8], got, vld);
            check($sformatf("R%0d vector %0d valid", VEC[i][83:80], i), int'(vld), 1);
            check($sformatf("R%0d vector %0d data", VEC[i][83:80], i), got,
                  int'($signed(VEC[i][7:0])));
        end

        // R7: latency and one-per-cycle throughput, pass-through config
        set_cfg(32'h47000000, 8'd0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 1 || i == 2) check("R7 no early output", int'(out_valid), 0);
            if (i >= 3) begin
                check("R7 stream valid", int'(out_valid), 1);
                check("R7 stream data", int'($signed(out_data)), 11 * (i - 2));
            end
            if (i < 5) begin
                in_valid = 1'b1;
                in_acc   = 32'(11 * (i + 1));
            end else begin
                in_valid = 1'b0;
            end
        end

        // R8: backpressure fill, hold and drain
        @(negedge clk);
        out_ready = 1'b0;
        nacc = 0;
        while (in_ready && nacc < 8) begin
            in_valid = 1'b1;
            in_acc   = 32'(10 * (nacc + 1));
            nacc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R8 samples accepted before stall", nacc, 3);
        check("R8 in_ready low when full", int'(in_ready), 0);
        repeat (4) @(negedge clk);
        check("R8 held valid", int'(out_valid), 1);
        check("R8 held data", int'($signed(out_data)), 10);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_acc    = 32'd40;
        seen[0]   = int'($signed(out_data));
        @(posedge clk);
        #1 in_valid = 1'b0;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            check("R8 drain valid", int'(out_valid), 1);
            seen[k] = int'($signed(out_data));
        end
        for (int k = 0; k < 4; k++) check("R8 drain order", seen[k], 10 * (k + 1));
        @(negedge clk);
        check("R8 no duplicate", int'(out_valid), 0);

        // R9: config written on the same edge as a sample
        @(negedge clk);
        cfg_valid      = 1'b1;
        cfg_scale      = 32'h3F000000;
        cfg_zero_point = 8'd5;
        in_valid       = 1'b1;
        in_acc         = 32'd100;
        @(negedge clk);
        cfg_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 old config valid", int'(out_valid), 1);
        check("R9 old config data", int'($signed(out_data)), 100);
        @(negedge clk);
        check("R9 new config valid", int'(out_valid), 1);
        check("R9 new config data", int'($signed(out_data)), 5);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule